// File: doc/BRIEF.md
# Two-Cell Pack Fault Sequencer

This block is the digital supervisor for a two-cell lithium-ion pack. An analog front end turns the cell and load-node voltages into comparator flags. The sequencer qualifies each flag with a counted delay, measured in ticks of a slow timebase strobe. From the qualified faults it decides whether the charge switch and the discharge switch may be on. It also selects which return path biases the charger-minus node, and it signals when the pack has entered its low-power standby.

Two cooperating controllers make up the block. The charge side holds one over-charge state with separate detect and release counts. The discharge side is a small state machine with five states: normal running, standby after over-discharge, a wake phase after the charger brings the node back, over-current and short circuit. Over-charge outranks over-current and standby entry. Short circuit is detected in every state. A test input cuts every counted delay to a single tick.

Top module: `cell_guard_seq`

## Requirements
- R1: While reset is asserted and right after it, chg_en_o and dsg_en_o are 1 and standby_o, pull_up_o, pull_dn_o and pull_dn_strong_o are 0.
- R2: When bit k of ovc_i (1 = cell k at or above the over-charge level) stays 1 for OVC_DET_TICKS ticks, chg_en_o goes to 0.
- R3: With load_i at 0, chg_en_o returns to 1 after both bits of ovc_rel_i (1 = cell at or below the release level) are 1 for OVC_REL_TICKS ticks. With load_i at 1, it returns after both ovc_i bits are 0 for that long. While load_i is 1 and any ovc_i bit is 1, it stays 0.
- R4: Any ovd_i bit (1 = cell at or below the over-discharge level) held for OVD_DET_TICKS ticks drives dsg_en_o to 0 and sets standby_o and pull_up_o.
- R5: Standby is left only when stby_ret_i is 1. Leaving it clears standby_o at once, and dsg_en_o returns to 1 only after both ovd_i bits are 0 for OVD_REL_TICKS ticks.
- R6: ocur_i held for OCUR_DET_TICKS ticks drives dsg_en_o to 0 and sets pull_dn_o, with standby_o left at 0.
- R7: short_i held for SHORT_DET_TICKS ticks (fewer than OCUR_DET_TICKS) drives dsg_en_o to 0 and sets pull_dn_strong_o. This happens in any state, including during over-charge, and never sets standby_o.
- R8: From over-current or short circuit, dsg_en_o returns to 1 and both pull-down controls clear once ocur_i has been 0 for OCUR_REL_TICKS ticks.
- R9: While chg_en_o is 0 because of over-charge, ocur_i is not qualified: dsg_en_o and pull_dn_o are unchanged.
- R10: An over-discharge qualified during over-charge drives dsg_en_o to 0 but keeps standby_o and pull_up_o at 0. Once over-charge releases with the discharge fault still pending, standby_o and pull_up_o go to 1.
- R11: With test_i at 1, every qualification and release takes a single tick.
- R12: A flag that drops before its count completes clears that count, so repeated short pulses never change an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one clock wide |
| test_i | input | 1 | Shortens all counted delays to one tick |
| ovc_i | input | 2 | Per-cell over-charge level flag |
| ovc_rel_i | input | 2 | Per-cell at-or-below release level flag |
| ovd_i | input | 2 | Per-cell over-discharge flag |
| ocur_i | input | 1 | Load node above over-current level |
| short_i | input | 1 | Load node above short-circuit level |
| stby_ret_i | input | 1 | Load node at or below standby return level |
| load_i | input | 1 | Load connected |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| standby_o | output | 1 | Low-power standby active |
| pull_up_o | output | 1 | Load node pulled to supply |
| pull_dn_o | output | 1 | Load node pulled to ground, weak path |
| pull_dn_strong_o | output | 1 | Load node pulled to ground, strong path |

## Verification
The bench builds the block with short delays: 20 ticks to detect over-charge and 8 to release it, 12 and 3 for over-discharge, 6 and 4 for over-current, and 2 for short circuit. A tick arrives every four clocks. With these values every fault can be entered and left many times within one run. The bench can land directly on either side of each count boundary, and random pulse lengths around the over-current count test the restart rule thoroughly.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [2:0] {
    DS_RUN   = 3'd0,
    DS_SLEEP = 3'd1,
    DS_WAKE  = 3'd2,
    DS_OCUR  = 3'd3,
    DS_SHORT = 3'd4
  } dsg_state_e;

  function automatic int unsigned cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction
endpackage

// File: rtl/cgs_delay.sv
module cgs_delay #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic test_i,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned W = cgs_pkg::cnt_width(LEN);

  logic [W-1:0] cnt_q, lim;

  assign lim = test_i ? W'(1) : W'(LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!cond_i)              cnt_q <= '0;
    else if (tick_i && cnt_q < lim) cnt_q <= cnt_q + W'(1);
  end

  assign done_o = cond_i && (cnt_q >= lim);

  // R12
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cond_i) |-> cnt_q == '0);

  // R12
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(LEN));
endmodule

// File: rtl/cgs_chg.sv
module cgs_chg #(
  parameter int unsigned DET_TICKS = 1000,
  parameter int unsigned REL_TICKS = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       test_i,
  input  logic [1:0] ovc_i,
  input  logic [1:0] ovc_rel_i,
  input  logic       load_i,
  output logic       active_o
);
  logic active_q, det_cond, rel_cond, det_hit, rel_hit;

  assign det_cond = !active_q && (|ovc_i);
  // with a load, falling below the detect level is enough
  assign rel_cond = active_q && (load_i ? !(|ovc_i) : (&ovc_rel_i));

  cgs_delay #(.LEN(DET_TICKS)) u_det (
    .clk_i, .rst_ni, .tick_i, .test_i, .cond_i(det_cond), .done_o(det_hit));
  cgs_delay #(.LEN(REL_TICKS)) u_rel (
    .clk_i, .rst_ni, .tick_i, .test_i, .cond_i(rel_cond), .done_o(rel_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (det_hit) active_q <= 1'b1;
    else if (rel_hit) active_q <= 1'b0;
  end

  assign active_o = active_q;

  // R3
  load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(active_q) && $past(load_i) && $past(|ovc_i)) |-> active_q);
endmodule

// File: rtl/cgs_dsg.sv
module cgs_dsg
  import cgs_pkg::*;
#(
  parameter int unsigned OVD_DET_TICKS   = 100,
  parameter int unsigned OVD_REL_TICKS   = 1,
  parameter int unsigned OCUR_DET_TICKS  = 5,
  parameter int unsigned OCUR_REL_TICKS  = 1,
  parameter int unsigned SHORT_DET_TICKS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       test_i,
  input  logic [1:0] ovd_i,
  input  logic       ocur_i,
  input  logic       short_i,
  input  logic       stby_ret_i,
  input  logic       ovc_active_i,
  output logic       dsg_en_o,
  output logic       standby_o,
  output logic       pull_up_o,
  output logic       pull_dn_o,
  output logic       pull_dn_strong_o
);
  dsg_state_e state_q, state_d;

  logic ovd_det_c, ovd_rel_c, ocur_det_c, ocur_rel_c, short_det_c;
  logic ovd_det_h, ovd_rel_h, ocur_det_h, ocur_rel_h, short_det_h;

  assign ovd_det_c   = (state_q == DS_RUN || state_q == DS_WAKE) && (|ovd_i);
  assign ovd_rel_c   = (state_q == DS_WAKE) && !(|ovd_i);
  assign ocur_det_c  = (state_q == DS_RUN) && ocur_i && !ovc_active_i;
  assign ocur_rel_c  = (state_q == DS_OCUR || state_q == DS_SHORT) && !ocur_i;
  assign short_det_c = (state_q != DS_SHORT) && short_i;

  cgs_delay #(.LEN(OVD_DET_TICKS)) u_ovd_det (
    .clk_i, .rst_ni, .tick_i, .test_i, .cond_i(ovd_det_c), .done_o(ovd_det_h));
  cgs_delay #(.LEN(OVD_REL_TICKS)) u_ovd_rel (
    .clk_i, .rst_ni, .tick_i, .test_i, .cond_i(ovd_rel_c), .done_o(ovd_rel_h));
  cgs_delay #(.LEN(OCUR_DET_TICKS)) u_ocur_det (
    .clk_i, .rst_ni, .tick_i, .test_i, .cond_i(ocur_det_c), .done_o(ocur_det_h));
  cgs_delay #(.LEN(OCUR_REL_TICKS)) u_ocur_rel (
    .clk_i, .rst_ni, .tick_i, .test_i, .cond_i(ocur_rel_c), .done_o(ocur_rel_h));
  cgs_delay #(.LEN(SHORT_DET_TICKS)) u_short_det (
    .clk_i, .rst_ni, .tick_i, .test_i, .cond_i(short_det_c), .done_o(short_det_h));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      DS_RUN: begin
        if (short_det_h)     state_d = DS_SHORT;
        else if (ovd_det_h)  state_d = DS_SLEEP;
        else if (ocur_det_h) state_d = DS_OCUR;
      end
      DS_SLEEP: begin
        if (short_det_h)     state_d = DS_SHORT;
        else if (stby_ret_i) state_d = DS_WAKE;
      end
      DS_WAKE: begin
        if (short_det_h)     state_d = DS_SHORT;
        else if (ovd_det_h)  state_d = DS_SLEEP;
        else if (ovd_rel_h)  state_d = DS_RUN;
      end
      DS_OCUR: begin
        if (short_det_h)     state_d = DS_SHORT;
        else if (ocur_rel_h) state_d = DS_RUN;
      end
      DS_SHORT: begin
        if (ocur_rel_h)      state_d = DS_RUN;
      end
      default:               state_d = DS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= DS_RUN;
    else         state_q <= state_d;
  end

  // standby held off while over-charge owns the pack
  assign standby_o        = (state_q == DS_SLEEP) && !ovc_active_i;
  assign pull_up_o        = standby_o;
  assign pull_dn_o        = (state_q == DS_OCUR);
  assign pull_dn_strong_o = (state_q == DS_SHORT);
  assign dsg_en_o         = (state_q == DS_RUN);

  // R9
  ocur_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == DS_OCUR && $past(state_q) != DS_OCUR) |-> !$past(ovc_active_i));

  // R7
  short_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_dn_strong_o) |-> $past(short_i));

  // R5
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == DS_SLEEP && state_q == DS_WAKE) |-> $past(stby_ret_i));

  // R6
  path_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pull_up_o, pull_dn_o, pull_dn_strong_o}));
endmodule

// File: rtl/cell_guard_seq.sv
module cell_guard_seq #(
  parameter int unsigned OVC_DET_TICKS   = 1000,
  parameter int unsigned OVC_REL_TICKS   = 40,
  parameter int unsigned OVD_DET_TICKS   = 100,
  parameter int unsigned OVD_REL_TICKS   = 1,
  parameter int unsigned OCUR_DET_TICKS  = 5,
  parameter int unsigned OCUR_REL_TICKS  = 1,
  parameter int unsigned SHORT_DET_TICKS = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       test_i,
  input  logic [1:0] ovc_i,
  input  logic [1:0] ovc_rel_i,
  input  logic [1:0] ovd_i,
  input  logic       ocur_i,
  input  logic       short_i,
  input  logic       stby_ret_i,
  input  logic       load_i,
  output logic       chg_en_o,
  output logic       dsg_en_o,
  output logic       standby_o,
  output logic       pull_up_o,
  output logic       pull_dn_o,
  output logic       pull_dn_strong_o
);
  logic ovc_active;

  cgs_chg #(
    .DET_TICKS(OVC_DET_TICKS),
    .REL_TICKS(OVC_REL_TICKS)
  ) u_chg (
    .clk_i, .rst_ni, .tick_i, .test_i,
    .ovc_i, .ovc_rel_i, .load_i,
    .active_o(ovc_active)
  );

  cgs_dsg #(
    .OVD_DET_TICKS  (OVD_DET_TICKS),
    .OVD_REL_TICKS  (OVD_REL_TICKS),
    .OCUR_DET_TICKS (OCUR_DET_TICKS),
    .OCUR_REL_TICKS (OCUR_REL_TICKS),
    .SHORT_DET_TICKS(SHORT_DET_TICKS)
  ) u_dsg (
    .clk_i, .rst_ni, .tick_i, .test_i,
    .ovd_i, .ocur_i, .short_i, .stby_ret_i,
    .ovc_active_i(ovc_active),
    .dsg_en_o, .standby_o, .pull_up_o, .pull_dn_o, .pull_dn_strong_o
  );

  assign chg_en_o = !ovc_active;

  // R2
  ovc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chg_en_o) |-> $past(|ovc_i));

  // R4
  standby_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !dsg_en_o && !chg_en_o == 1'b0);

  // R1
  reset_val_chk: assert property (@(posedge clk_i)
    !rst_ni |-> chg_en_o && dsg_en_o && !standby_o);
endmodule

// File: tb/cell_guard_seq_tb.sv
module cell_guard_seq_tb;
  localparam int OVC_DET  = 20;
  localparam int OVC_REL  = 8;
  localparam int OVD_DET  = 12;
  localparam int OVD_REL  = 3;
  localparam int OCUR_DET = 6;
  localparam int OCUR_REL = 4;
  localparam int SHRT_DET = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, test = 1'b0;
  logic [1:0] ovc = 2'b00, rel = 2'b11, ovd = 2'b00;
  logic ocur = 1'b0, shrt = 1'b0, sret = 1'b0, load = 1'b0;
  logic chg_en, dsg_en, stby, pu, pd, pds;

  int vectors = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cell_guard_seq #(
    .OVC_DET_TICKS(OVC_DET), .OVC_REL_TICKS(OVC_REL),
    .OVD_DET_TICKS(OVD_DET), .OVD_REL_TICKS(OVD_REL),
    .OCUR_DET_TICKS(OCUR_DET), .OCUR_REL_TICKS(OCUR_REL),
    .SHORT_DET_TICKS(SHRT_DET)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .test_i(test),
    .ovc_i(ovc), .ovc_rel_i(rel), .ovd_i(ovd), .ocur_i(ocur),
    .short_i(shrt), .stby_ret_i(sret), .load_i(load),
    .chg_en_o(chg_en), .dsg_en_o(dsg_en), .standby_o(stby),
    .pull_up_o(pu), .pull_dn_o(pd), .pull_dn_strong_o(pds)
  );

  // one tick every four clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      tick = (ph == 0);
    end
  end

  function automatic bit trips(input int held, input int len);
    return held > len;
  endfunction

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    clocks(4 * n);
  endtask

  task automatic wake_up();
    ovd = 2'b00;
    sret = 1'b1;
    clocks(1);
    sret = 1'b0;
    ticks(OVD_REL + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int c, k, h;
    void'($urandom(32'd1234));
    clocks(3);
    // R1
    chk(chg_en, 1'b1, "R1", "chg_en in reset");
    chk(dsg_en, 1'b1, "R1", "dsg_en in reset");
    chk(stby | pu | pd | pds, 1'b0, "R1", "paths in reset");
    rst_n = 1'b1;
    clocks(2);
    chk(chg_en & dsg_en, 1'b1, "R1", "enables after reset");

    // R12 glitches on over-charge
    c = int'($urandom % 2);
    k = 1 + int'($urandom % (OVC_DET - 1));
    ovc[c] = 1'b1; ticks(k); ovc = 2'b00; ticks(2);
    chk(chg_en, 1'b1, "R12", "short ovc pulse");
    ovc[c] = 1'b1; ticks(OVC_DET - 1); ovc = 2'b00; clocks(2);
    chk(chg_en, 1'b1, "R12", "count restarted");

    // R2 detect
    ovc[c] = 1'b1; rel[c] = 1'b0;
    ticks(OVC_DET - 1);
    chk(chg_en, 1'b1, "R2", "before ovc count");
    clocks(6);
    chk(chg_en, 1'b0, "R2", "after ovc count");

    // R3 release with load
    load = 1'b1;
    ticks(OVC_REL + 2);
    chk(chg_en, 1'b0, "R3", "load with cell above level");
    ovc = 2'b00;
    ticks(OVC_REL - 1);
    chk(chg_en, 1'b0, "R3", "load release early");
    clocks(6);
    chk(chg_en, 1'b1, "R3", "load release done");
    load = 1'b0;

    // R3 release without load
    ovc[c] = 1'b1; ticks(OVC_DET); clocks(2);
    chk(chg_en, 1'b0, "R2", "second detect");
    ovc = 2'b00;
    ticks(OVC_REL + 3);
    chk(chg_en, 1'b0, "R3", "no load, above release");
    rel = 2'b11;
    ticks(OVC_REL - 1);
    chk(chg_en, 1'b0, "R3", "no load release early");
    clocks(6);
    chk(chg_en, 1'b1, "R3", "no load release done");

    // R9 over-current masked during over-charge
    ovc[c] = 1'b1; rel[c] = 1'b0; ticks(OVC_DET); clocks(2);
    ocur = 1'b1;
    ticks(OCUR_DET + 3);
    chk(dsg_en, 1'b1, "R9", "dsg_en during masked ocur");
    chk(pd, 1'b0, "R9", "pull_dn during masked ocur");

    // R7 short during over-charge
    shrt = 1'b1;
    ticks(SHRT_DET - 1);
    chk(pds, 1'b0, "R7", "short before count");
    clocks(6);
    chk(pds, 1'b1, "R7", "short strong path");
    chk(dsg_en, 1'b0, "R7", "short dsg_en");
    chk(pd | stby, 1'b0, "R7", "short weak path/standby");
    chk(chg_en, 1'b0, "R7", "over-charge kept");

    // R8 release from short
    shrt = 1'b0; ocur = 1'b0;
    ticks(OCUR_REL - 1);
    chk(dsg_en, 1'b0, "R8", "short release early");
    clocks(6);
    chk(dsg_en, 1'b1, "R8", "short release done");
    chk(pds, 1'b0, "R8", "strong path cleared");
    ovc = 2'b00; rel = 2'b11; ticks(OVC_REL + 2);
    chk(chg_en, 1'b1, "R3", "recharge enable");

    // R10 over-discharge under over-charge
    ovc[c] = 1'b1; rel[c] = 1'b0; ticks(OVC_DET); clocks(2);
    ovd[1-c] = 1'b1;
    ticks(OVD_DET + 2);
    chk(dsg_en, 1'b0, "R10", "dsg_en off");
    chk(stby | pu, 1'b0, "R10", "standby held off");
    ovc = 2'b00; rel = 2'b11;
    ticks(OVC_REL - 1);
    chk(stby, 1'b0, "R10", "standby before ovc release");
    clocks(6);
    chk(stby & pu, 1'b1, "R10", "standby after ovc release");
    chk(chg_en, 1'b1, "R10", "chg_en back");

    // R5 standby exit
    ovd = 2'b00;
    ticks(OVD_REL + 3);
    chk(stby, 1'b1, "R5", "standby kept without return flag");
    chk(dsg_en, 1'b0, "R5", "dsg_en off in standby");
    sret = 1'b1; clocks(1); sret = 1'b0;
    chk(stby, 1'b0, "R5", "standby left");
    chk(dsg_en, 1'b0, "R5", "dsg_en before release count");
    ticks(OVD_REL + 1);
    chk(dsg_en, 1'b1, "R5", "dsg_en after release count");

    // R4 plain over-discharge
    ovd[c] = 1'b1;
    ticks(OVD_DET - 1);
    chk(dsg_en, 1'b1, "R4", "before ovd count");
    clocks(6);
    chk(dsg_en, 1'b0, "R4", "dsg_en off");
    chk(stby & pu, 1'b1, "R4", "standby and pull-up");
    chk(pd, 1'b0, "R4", "no pull-down");
    wake_up();
    chk(dsg_en, 1'b1, "R5", "recovered");

    // R6 / R8 over-current
    ocur = 1'b1;
    ticks(OCUR_DET - 1);
    chk(dsg_en, 1'b1, "R6", "before ocur count");
    clocks(6);
    chk(dsg_en, 1'b0, "R6", "dsg_en off");
    chk(pd, 1'b1, "R6", "pull-down on");
    chk(stby, 1'b0, "R6", "no standby");
    ocur = 1'b0;
    ticks(OCUR_REL - 1);
    chk(dsg_en, 1'b0, "R8", "ocur release early");
    clocks(6);
    chk(dsg_en, 1'b1, "R8", "ocur release done");
    chk(pd, 1'b0, "R8", "pull-down off");

    // R11 test mode
    test = 1'b1;
    ovc[c] = 1'b1; rel[c] = 1'b0; clocks(6);
    chk(chg_en, 1'b0, "R11", "fast ovc detect");
    ovc = 2'b00; rel = 2'b11; clocks(6);
    chk(chg_en, 1'b1, "R11", "fast ovc release");
    ocur = 1'b1; clocks(6);
    chk(dsg_en, 1'b0, "R11", "fast ocur detect");
    ocur = 1'b0; clocks(6);
    chk(dsg_en, 1'b1, "R11", "fast ocur release");
    ovd[c] = 1'b1; clocks(6);
    chk(stby, 1'b1, "R11", "fast ovd detect");
    test = 1'b0;
    wake_up();
    chk(dsg_en, 1'b1, "R11", "recovered from fast ovd");

    // R12 / R6 random over-current pulses
    for (int i = 0; i < 24; i++) begin
      if ($urandom % 2 == 0) h = 1 + int'($urandom % (OCUR_DET - 1));
      else                   h = OCUR_DET + 1 + int'($urandom % 3);
      ocur = 1'b1; ticks(h); ocur = 1'b0; clocks(2);
      chk(dsg_en, trips(h, OCUR_DET) ? 1'b0 : 1'b1, "R12", $sformatf("ocur pulse %0d ticks", h));
      ticks(OCUR_REL + 2);
      chk(dsg_en, 1'b1, "R8", "after random pulse");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule